// File: doc/BRIEF.md
# Serial Peripheral Master with Queued Transmit

This block is the master side of a four-wire serial peripheral link. A host hands it bytes over a valid/ready transmit stream. Each accepted byte waits in a one-byte holding register until the shift engine is free. It is then copied into the shift register and sent most significant bit first on `mosi`, while `miso` is shifted in. The clock `sck` rests low. The master changes `mosi` on every rising edge and samples `miso` on every falling edge. Each half period of `sck` lasts `HALF_DIV` system clocks.

Because the holding register is separate from the shift register, the host can queue the next byte while the current one is still going out. A queued byte follows the previous frame with no pause. The received byte is presented on a valid/ready receive stream, and a read handshake consumes it. Back-pressure works as follows. On transmit, `tx_ready` is high only while the holding register is empty and the block is enabled, and `tx_valid` outside that window has no effect. On receive, a completed byte that finds the previous one unread is dropped and raises the overflow flag. An active-low fault input marks a second master on the bus. It stops the transfer in progress and latches a mode-fault flag.

Two interrupt lines combine the flags with enable bits. One serves the transmitter. The other is shared by the receiver and the two error flags. Clearing the global enable returns every flag to its reset state and drops any queued byte.

Top module: `spi_qmaster`

## Requirements
- R1: After reset, `sck` and `mosi` are low, `rx_valid`, `ovr_flag`, `modf_flag`, `tx_irq` and `rxe_irq` are low, and `tx_ready` is high once `spi_en` is high.
- R2: A transmit byte is accepted only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_valid` while `tx_ready` is low changes neither the queued byte nor the bytes sent.
- R3: A frame is 8 bits, most significant first. `sck` idles low, `mosi` changes only at a rising `sck` edge, and `miso` is sampled at each falling edge into the received byte.
- R4: An accepted write makes `tx_ready` low in the next cycle. `tx_ready` (transmitter empty) returns high in the cycle the byte moves into the shift register, which happens one cycle after the write when the shifter is idle.
- R5: A byte queued during a frame starts right after that frame's last falling edge. Every `sck` half period across both frames lasts exactly `HALF_DIV` clocks.
- R6: When a frame ends with no unread byte, `rx_valid` goes high with the received byte on `rx_data`. A cycle with `rx_valid` and `rx_ready` both high consumes it.
- R7: A frame that ends while `rx_valid` is high sets `ovr_flag`, and `rx_data` keeps the older byte. The next read clears both `rx_valid` and `ovr_flag`.
- R8: `fault_n` low while enabled sets `modf_flag` three clocks after it falls (two synchronizer stages and the flag register). In that same cycle the frame is aborted: `sck` returns low and no byte is received.
- R9: `tx_irq` is high exactly when `spi_en`, `tx_ie` and transmitter-empty are all high.
- R10: `rxe_irq` is high when `spi_en` is high and either `rx_valid` and `rx_ie` are high, or `err_ie` is high with `ovr_flag` or `modf_flag` high.
- R11: With `spi_en` low, the frame stops with `sck` low, the flags clear, the queued byte is dropped, `tx_ready` is low and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Global enable |
| tx_ie | input | 1 | Transmitter interrupt enable |
| rx_ie | input | 1 | Receiver interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty and block enabled |
| tx_data | input | FRAME_W | Transmit byte |
| rx_valid | output | 1 | Receiver full |
| rx_ready | input | 1 | Host consumes the received byte |
| rx_data | output | FRAME_W | Received byte |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fault_n | input | 1 | Active-low bus-conflict input |
| ovr_flag | output | 1 | Receive overflow |
| modf_flag | output | 1 | Mode fault |
| tx_irq | output | 1 | Transmitter interrupt request |
| rxe_irq | output | 1 | Receiver/error interrupt request |

## Verification
A wrong bit counter or phase register shows on the pins within one frame. A shifted or stretched `sck` edge, or a byte that loops back wrong, is visible after about `16*HALF_DIV` clocks. A stuck transmitter-empty flag shows on `tx_ready` and `tx_irq` one cycle after a write. A faulty receive-full or overflow update shows the moment a second frame ends unread, as a changed `rx_data` or a missing `ovr_flag`. The fault path is checked against its exact three-cycle latency, so an extra or missing synchronizer stage is caught at once.

// File: rtl/spi_qm_pkg.sv
package spi_qm_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/spi_qm_baud.sv
module spi_qm_baud #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = spi_qm_pkg::cnt_w(HALF_DIV);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/spi_qm_shifter.sv
module spi_qm_shifter #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               halt,
  input  logic               start_ok,
  input  logic               buf_full,
  input  logic [FRAME_W-1:0] buf_data,
  input  logic               miso,
  output logic               load,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               run,
  output logic               sck,
  output logic               mosi
);
  import spi_qm_pkg::*;

  localparam int unsigned BW = cnt_w(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  sh_state_e          state;
  logic               phase;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] shreg;
  logic               last_fall;
  logic               chain;

  assign run       = (state == SH_RUN);
  assign last_fall = run && tick && phase && (bitn == LAST_BIT);
  assign chain     = start_ok && buf_full;
  assign load      = !halt && chain && ((state == SH_IDLE) || last_fall);
  assign frame_done = !halt && last_fall;
  assign rx_byte   = {shreg[FRAME_W-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      phase <= 1'b0;
      bitn  <= '0;
      shreg <= '0;
      sck   <= 1'b0;
      mosi  <= 1'b0;
    end else if (halt) begin
      state <= SH_IDLE;
      phase <= 1'b0;
      bitn  <= '0;
      sck   <= 1'b0;
    end else begin
      unique case (state)
        SH_IDLE: begin
          if (chain) begin
            shreg <= buf_data;
            state <= SH_RUN;
            phase <= 1'b0;
            bitn  <= '0;
          end
        end
        SH_RUN: begin
          if (tick) begin
            if (!phase) begin
              sck   <= 1'b1;
              mosi  <= shreg[FRAME_W-1];
              phase <= 1'b1;
            end else begin
              sck   <= 1'b0;
              phase <= 1'b0;
              if (bitn == LAST_BIT) begin
                bitn <= '0;
                if (chain) shreg <= buf_data;
                else begin
                  shreg <= rx_byte;
                  state <= SH_IDLE;
                end
              end else begin
                shreg <= rx_byte;
                bitn  <= bitn + 1'b1;
              end
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_qm_status.sv
module spi_qm_status #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_en,
  input  logic               tx_ie,
  input  logic               rx_ie,
  input  logic               err_ie,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               rx_ready,
  input  logic               fault_n,
  input  logic               load,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] rx_byte,
  output logic               tx_empty,
  output logic [FRAME_W-1:0] tx_hold,
  output logic               rx_full,
  output logic [FRAME_W-1:0] rx_hold,
  output logic               ovr,
  output logic               modf,
  output logic               fault_hit,
  output logic               tx_irq,
  output logic               rxe_irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   wr_acc;
  logic                   rd_acc;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= fault_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n};
      end
    end
  endgenerate

  assign fault_hit = spi_en && !sync_q[SYNC_STAGES-1];
  assign wr_acc    = spi_en && tx_empty && tx_valid;
  assign rd_acc    = rx_full && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         modf <= 1'b0;
    else if (!spi_en)   modf <= 1'b0;
    else if (fault_hit) modf <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      tx_hold  <= '0;
    end else if (!spi_en) begin
      tx_empty <= 1'b1;
    end else if (wr_acc) begin
      tx_empty <= 1'b0;
      tx_hold  <= tx_data;
    end else if (load) begin
      tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_hold <= '0;
      ovr     <= 1'b0;
    end else if (!spi_en) begin
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (rd_acc) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
      end
      if (frame_done) begin
        if (rx_full && !rd_acc) begin
          ovr <= 1'b1;
        end else begin
          rx_full <= 1'b1;
          rx_hold <= rx_byte;
        end
      end
    end
  end

  assign tx_irq  = spi_en && tx_ie && tx_empty;
  assign rxe_irq = spi_en && ((rx_ie && rx_full) || (err_ie && (ovr || modf)));

endmodule

// File: rtl/spi_qmaster.sv
module spi_qmaster #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_en,
  input  logic               tx_ie,
  input  logic               rx_ie,
  input  logic               err_ie,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_data,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  input  logic               fault_n,
  output logic               ovr_flag,
  output logic               modf_flag,
  output logic               tx_irq,
  output logic               rxe_irq
);
  logic               tick;
  logic               run;
  logic               load;
  logic               frame_done;
  logic [FRAME_W-1:0] rx_byte;
  logic               tx_empty;
  logic [FRAME_W-1:0] tx_hold;
  logic               fault_hit;
  logic               halt;
  logic               start_ok;

  assign halt     = !spi_en || fault_hit;
  assign start_ok = spi_en && !modf_flag && !fault_hit;
  assign tx_ready = spi_en && tx_empty;

  spi_qm_baud #(.HALF_DIV(HALF_DIV)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  spi_qm_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .halt       (halt),
    .start_ok   (start_ok),
    .buf_full   (!tx_empty),
    .buf_data   (tx_hold),
    .miso       (miso),
    .load       (load),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .run        (run),
    .sck        (sck),
    .mosi       (mosi)
  );

  spi_qm_status #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_en     (spi_en),
    .tx_ie      (tx_ie),
    .rx_ie      (rx_ie),
    .err_ie     (err_ie),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .rx_ready   (rx_ready),
    .fault_n    (fault_n),
    .load       (load),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .tx_empty   (tx_empty),
    .tx_hold    (tx_hold),
    .rx_full    (rx_valid),
    .rx_hold    (rx_data),
    .ovr        (ovr_flag),
    .modf       (modf_flag),
    .fault_hit  (fault_hit),
    .tx_irq     (tx_irq),
    .rxe_irq    (rxe_irq)
  );

endmodule

// File: rtl/spi_qmaster_chk.sv
module spi_qmaster_chk #(
  parameter int unsigned FRAME_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_en,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic               rx_valid,
  input logic               rx_ready,
  input logic [FRAME_W-1:0] rx_data,
  input logic               sck,
  input logic               mosi,
  input logic               ovr_flag,
  input logic               modf_flag,
  input logic               tx_irq,
  input logic               frame_done
);

  // R3: data out holds steady while the clock stays high
  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R4: an accepted write empties the ready window
  assert_write_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R6: a read with no completing frame consumes the byte
  assert_read_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !frame_done) |=> !rx_valid);

  // R7: the unread byte survives an overflow
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $stable(rx_data));

  // R8: a fault keeps the clock parked low
  assert_fault_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    modf_flag |-> !sck);

  // R9: transmitter request only when a byte can be taken
  assert_txirq_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_ready);

  // R11: disabling clears every flag on the next edge
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |=> (!rx_valid && !ovr_flag && !modf_flag));

endmodule

bind spi_qmaster spi_qmaster_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_en     (spi_en),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .sck        (sck),
  .mosi       (mosi),
  .ovr_flag   (ovr_flag),
  .modf_flag  (modf_flag),
  .tx_irq     (tx_irq),
  .frame_done (frame_done)
);

// File: tb/tb_spi_qmaster.sv
`timescale 1ns/1ps
module tb_spi_qmaster;
  localparam int unsigned FW = 8;
  localparam int unsigned HD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 1'b0, tx_ie = 1'b0, rx_ie = 1'b0, err_ie = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, fault_n = 1'b1;
  logic [FW-1:0] tx_data = '0;
  logic tx_ready, rx_valid, sck, mosi, miso, ovr_flag, modf_flag, tx_irq, rxe_irq;
  logic [FW-1:0] rx_data;
  logic inv = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign miso = inv ? ~mosi : mosi;

  spi_qmaster #(.FRAME_W(FW), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
    .err_ie(err_ie), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .sck(sck),
    .mosi(mosi), .miso(miso), .fault_n(fault_n), .ovr_flag(ovr_flag),
    .modf_flag(modf_flag), .tx_irq(tx_irq), .rxe_irq(rxe_irq)
  );

  // serial monitor: collects bytes seen on mosi at falling sck
  logic [FW-1:0] mon_sh = '0;
  int mon_bits = 0;
  logic [FW-1:0] mon_q [0:15];
  int mon_cnt = 0;
  always @(negedge sck) begin
    mon_sh = {mon_sh[FW-2:0], mosi};
    mon_bits = mon_bits + 1;
    if (mon_bits == FW) begin
      if (mon_cnt < 16) mon_q[mon_cnt] = mon_sh;
      mon_cnt = mon_cnt + 1;
      mon_bits = 0;
    end
  end

  // edge spacing monitor
  bit edge_chk = 1'b0;
  realtime last_edge = -1.0;
  int edge_n = 0;
  int edge_bad = 0;
  always @(sck) begin
    if (edge_chk) begin
      if (last_edge >= 0.0 && ($realtime - last_edge) != real'(HD * 8)) edge_bad = edge_bad + 1;
      last_edge = $realtime;
      edge_n = edge_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [FW-1:0] b);
    int w = 0;
    @(negedge clk);
    while (!tx_ready && w < 500) begin @(negedge clk); w++; end
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output bit ok);
    int w = 0;
    while (!rx_valid && w < 500) begin @(negedge clk); w++; end
    ok = rx_valid;
  endtask

  task automatic read_byte(output logic [FW-1:0] b);
    b = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sck", sck, 0);
    check("R1 mosi", mosi, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 flags", {ovr_flag, modf_flag}, 0);
    check("R1 irqs", {tx_irq, rxe_irq}, 0);
    check("R11 ready while disabled", tx_ready, 0);
    spi_en = 1'b1;
    @(negedge clk);
    check("R1 ready when enabled", tx_ready, 1);
  endtask

  task automatic t_single();
    bit ok;
    logic [FW-1:0] b;
    mon_bits = 0;
    mon_cnt = 0;
    tx_ie = 1'b1;
    rx_ie = 1'b1;
    @(negedge clk);
    check("R9 tx_irq when empty", tx_irq, 1);
    tx_valid = 1'b1;
    tx_data = 8'hA5;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R4 ready low after write", tx_ready, 0);
    check("R9 tx_irq low when full", tx_irq, 0);
    @(negedge clk);
    check("R4 empty after move to shifter", tx_ready, 1);
    wait_rx(ok);
    check("R6 rx_valid after frame", ok, 1);
    check("R6 rx_data loopback", rx_data, 8'hA5);
    check("R3 msb-first on mosi", mon_q[0], 8'hA5);
    check("R10 rxe_irq on receive", rxe_irq, 1);
    rx_ie = 1'b0;
    @(negedge clk);
    check("R10 rxe_irq gated", rxe_irq, 0);
    read_byte(b);
    check("R6 read clears", rx_valid, 0);
    tx_ie = 1'b0;
  endtask

  task automatic t_invert();
    bit ok;
    logic [FW-1:0] b;
    mon_bits = 0;
    mon_cnt = 0;
    inv = 1'b1;
    write_byte(8'h3C);
    wait_rx(ok);
    check("R3 miso sampled", rx_data, 8'hC3);
    check("R3 sck idle low after frame", sck, 0);
    read_byte(b);
    inv = 1'b0;
  endtask

  task automatic t_burst();
    bit ok;
    logic [FW-1:0] b;
    mon_bits = 0;
    mon_cnt = 0;
    edge_n = 0;
    edge_bad = 0;
    last_edge = -1.0;
    edge_chk = 1'b1;
    write_byte(8'h96);
    write_byte(8'h4D);
    check("R2 ready low while queued", tx_ready, 0);
    tx_valid = 1'b1;
    tx_data = 8'hFF;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_rx(ok);
    check("R5 first byte", rx_data, 8'h96);
    read_byte(b);
    wait_rx(ok);
    check("R2 queued byte kept", rx_data, 8'h4D);
    read_byte(b);
    cycles(60);
    edge_chk = 1'b0;
    check("R5 edge count", edge_n, 32);
    check("R5 no gap between frames", edge_bad, 0);
    check("R2 ignored write not sent", mon_cnt, 2);
  endtask

  task automatic t_overflow();
    bit ok;
    logic [FW-1:0] b;
    int w = 0;
    write_byte(8'h11);
    wait_rx(ok);
    write_byte(8'h22);
    while (!ovr_flag && w < 500) begin @(negedge clk); w++; end
    check("R7 overflow set", ovr_flag, 1);
    check("R7 old byte kept", rx_data, 8'h11);
    err_ie = 1'b1;
    @(negedge clk);
    check("R10 rxe_irq from overflow", rxe_irq, 1);
    read_byte(b);
    check("R7 read clears both", {rx_valid, ovr_flag}, 0);
    check("R10 rxe_irq cleared", rxe_irq, 0);
    err_ie = 1'b0;
  endtask

  task automatic t_modf();
    mon_bits = 0;
    mon_cnt = 0;
    write_byte(8'h5A);
    cycles(9);
    fault_n = 1'b0;
    cycles(2);
    check("R8 no flag before sync", modf_flag, 0);
    @(negedge clk);
    check("R8 flag after three clocks", modf_flag, 1);
    check("R8 sck parked", sck, 0);
    err_ie = 1'b1;
    @(negedge clk);
    check("R10 rxe_irq from fault", rxe_irq, 1);
    cycles(80);
    check("R8 no byte received", rx_valid, 0);
    spi_en = 1'b0;
    @(negedge clk);
    check("R11 fault cleared", modf_flag, 0);
    check("R11 irqs low", {tx_irq, rxe_irq}, 0);
    fault_n = 1'b1;
    err_ie = 1'b0;
    cycles(3);
    spi_en = 1'b1;
    cycles(2);
  endtask

  task automatic t_disable();
    write_byte(8'h81);
    write_byte(8'h42);
    cycles(6);
    spi_en = 1'b0;
    @(negedge clk);
    check("R11 sck low on disable", sck, 0);
    check("R11 ready low on disable", tx_ready, 0);
    @(negedge clk);
    spi_en = 1'b1;
    mon_bits = 0;
    mon_cnt = 0;
    cycles(100);
    check("R11 queued byte dropped", mon_cnt, 0);
    check("R11 no receive", rx_valid, 0);
    check("R11 ready after re-enable", tx_ready, 1);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_single();
    t_invert();
    t_burst();
    t_overflow();
    t_modf();
    t_disable();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule